// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer whose configuration cannot be changed by a stray bus write. A protected register can be written only after an unlock that takes two steps. Software first writes a fixed value to one key register. It then writes a second fixed value to another key register. The unlock covers exactly one protected write. After that write the lock closes again, so each change to the watchdog needs a fresh pair of keys.

The timer counts qualified ticks while it is enabled. When the count equals the programmed limit, a sticky expiry flag is set. A select bit in the control register chooses what the expiry drives: a reset request or an interrupt. The selected output stays high until software clears the flag through a protected write of 0. The block uses a simple single-cycle word-addressed bus, with combinational read data.

Register map (word addresses): 0 control (bit 0 run enable, bit 1 reset select), 1 limit, 2 count (read-only), 3 expiry flag (bit 0), 4 first key, 5 second key. The key registers and unused addresses read as 0.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, control reads 0, limit reads all ones (0xFFFF at the default width), count and expiry flag read 0, and both `wdt_rst_req` and `wdt_irq` are low.
- R2: The value 0x0000BABA written to address 4, followed by 0x0000EB10 written to address 5, opens the lock. The next bus access, if it is a write to address 0, 1 or 3, takes effect.
- R3: A write to address 0, 1 or 3 while the lock is closed leaves the register unchanged.
- R4: An open lock permits one protected write only. A second protected write with no new key pair is ignored.
- R5: A wrong first key, a wrong second key, or the two keys in reverse order leave the lock closed, and the next protected write is ignored.
- R6: Any bus access (read or write) between the second key and the protected write closes the lock, and the protected write is ignored.
- R7: With bit 0 of control set, the count advances by one on each cycle where `tick` is high. It holds when `tick` is low. A protected write to control resets it to 0.
- R8: On a tick where the count equals the limit, the expiry flag is set and the count returns to 0 and stops. With bit 1 of control set, `wdt_rst_req` rises, so the flag is set after limit+1 ticks.
- R9: With bit 1 of control clear, an expiry raises `wdt_irq` and leaves `wdt_rst_req` low.
- R10: The expiry flag, and with it the selected output, stays set until a protected write of 0 to address 3 clears it. An unprotected write of 0 to address 3 does not clear it.
- R11: A protected write with bit 0 equal to 1 to address 3 does not change the expiry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count qualifier, one count per high cycle |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| wdt_rst_req | output | 1 | Reset request while expired with reset select set |
| wdt_irq | output | 1 | Interrupt while expired with reset select clear |

## Verification
The hardest states to reach are the ones where the lock has been partly or fully opened and then should have been lost. These include a half-accepted key pair, keys in reverse order, and an open lock interrupted by a read. Each case is reached by issuing the exact bus sequence and then attempting a write to the limit register. Reading the limit back shows whether that write landed. The expiry path is reached by programming a short limit and counting the ticks to the cycle where the request rises. The flag is then attacked with unprotected and wrong-valued clears.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEYA  = 3'd4;
  localparam logic [ADDR_W-1:0] A_KEYB  = 3'd5;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;

endpackage

// File: rtl/kwdt_lock.sv
module kwdt_lock
  import kwdt_pkg::*;
#(
  parameter int unsigned   DATA_W = 32,
  parameter logic [31:0]   KEY_A  = 32'h0000_BABA,
  parameter logic [31:0]   KEY_B  = 32'h0000_EB10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              grant_o,
  output logic              open_o
);

  lock_state_e st_q, st_d;
  logic        is_prot;
  logic        key_a_hit, key_b_hit;

  always_comb begin
    is_prot   = (acc_addr == A_CTRL) || (acc_addr == A_LIMIT) || (acc_addr == A_FLAG);
    key_a_hit = acc_write && (acc_addr == A_KEYA) && (acc_wdata == KEY_A[DATA_W-1:0]);
    key_b_hit = acc_write && (acc_addr == A_KEYB) && (acc_wdata == KEY_B[DATA_W-1:0]);
  end

  always_comb begin
    st_d    = st_q;
    grant_o = 1'b0;
    if (acc_valid) begin
      if (key_a_hit) begin
        st_d = LK_HALF;
      end else if (key_b_hit && (st_q == LK_HALF)) begin
        st_d = LK_OPEN;
      end else begin
        st_d    = LK_SHUT;
        grant_o = (st_q == LK_OPEN) && acc_write && is_prot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == LK_OPEN);

  // R5: the lock only opens from the half-open state
  a_r5_open_via_half: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_OPEN && $past(st_q) != LK_OPEN) |-> $past(st_q == LK_HALF));

  // R4 and R6: any access made while open closes the lock
  a_r6_open_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_OPEN && acc_valid) |=> (st_q != LK_OPEN));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step  = tick_i && run_i;
    hit_o = step && (cnt_q == limit_i);
    cnt_d = cnt_q;
    if (restart_i)  cnt_d = '0;
    else if (hit_o) cnt_d = '0;
    else if (step)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7: without a qualified tick or a restart the count holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!tick_i || !run_i) && !$past(restart_i)) |-> $stable(cnt_q));

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              hit_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_en_o,
  output logic              rst_sel_o,
  output logic              flag_o,
  output logic              restart_o
);

  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [1:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] limit_q, limit_d;
  logic             flag_q, flag_d;
  logic             wr_ctrl, wr_limit, wr_flag;

  always_comb begin
    wr_ctrl  = grant_i && (addr_i == A_CTRL);
    wr_limit = grant_i && (addr_i == A_LIMIT);
    wr_flag  = grant_i && (addr_i == A_FLAG);

    ctrl_d  = wr_ctrl  ? wdata_i[1:0] : ctrl_q;
    limit_d = wr_limit ? wdata_i      : limit_q;

    flag_d = flag_q;
    if (hit_i)                        flag_d = 1'b1;
    else if (wr_flag && !wdata_i[0])  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= '1;
      flag_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      limit_q <= limit_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {{(DATA_W-2){1'b0}}, ctrl_q};
      A_LIMIT: rdata_o = {{PAD_W{1'b0}}, limit_q};
      A_COUNT: rdata_o = {{PAD_W{1'b0}}, cnt_i};
      A_FLAG:  rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
      default: rdata_o = '0;
    endcase
  end

  assign run_en_o  = ctrl_q[0];
  assign rst_sel_o = ctrl_q[1];
  assign flag_o    = flag_q;
  assign restart_o = wr_ctrl;

  // R3: the limit changes only right after the lock was open
  a_r3_limit_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(limit_q) |-> $past(open_i));

  // R3: the control register changes only right after the lock was open
  a_r3_ctrl_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(open_i));

  // R10: the expiry flag drops only through an unlocked write
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(open_i));

  // R8: the flag rises only from a counter match
  a_r8_flag_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit_i));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter logic [31:0] KEY_A  = 32'h0000_BABA,
  parameter logic [31:0] KEY_B  = 32'h0000_EB10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);

  logic             rst_s1_q, rst_s2_q;
  logic             grant, lock_open;
  logic             hit, run_en, rst_sel, flag, restart;
  logic [CNT_W-1:0] cnt;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  kwdt_lock #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .acc_valid (bus_valid),
    .acc_write (bus_write),
    .acc_addr  (bus_addr),
    .acc_wdata (bus_wdata),
    .grant_o   (grant),
    .open_o    (lock_open)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .tick_i    (tick),
    .run_i     (run_en && !flag),
    .restart_i (restart),
    .limit_i   (limit_w),
    .cnt_o     (cnt),
    .hit_o     (hit)
  );

  logic [CNT_W-1:0] limit_w;

  kwdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .grant_i   (grant),
    .open_i    (lock_open),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata[CNT_W-1:0]),
    .hit_i     (hit),
    .cnt_i     (cnt),
    .rdata_o   (bus_rdata),
    .run_en_o  (run_en),
    .rst_sel_o (rst_sel),
    .flag_o    (flag),
    .restart_o (restart)
  );

  assign limit_w     = u_regs.limit_q;
  assign wdt_rst_req = flag && rst_sel;
  assign wdt_irq     = flag && !rst_sel;

  // R9: interrupt and reset request are never raised together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !(wdt_rst_req && wdt_irq));

endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        bus_valid, bus_write;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req, wdt_irq;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  keyed_wdt uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd4, 32'h0000_BABA);
    wr(3'd5, 32'h0000_EB10);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 ctrl", d, 32'h0);
    rd(3'd1, d); check("R1 limit", d, 32'h0000_FFFF);
    rd(3'd2, d); check("R1 count", d, 32'h0);
    rd(3'd3, d); check("R1 flag", d, 32'h0);
    check("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
    check("R1 irq", {31'b0, wdt_irq}, 32'h0);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    wr(3'd1, 32'h1234);
    rd(3'd1, d); check("R3 locked limit", d, 32'h0000_FFFF);
    wr(3'd0, 32'h3);
    rd(3'd0, d); check("R3 locked ctrl", d, 32'h0);
  endtask

  task automatic t_unlock_and_single();
    logic [31:0] d;
    unlock(); wr(3'd1, 32'h40);
    rd(3'd1, d); check("R2 unlocked write", d, 32'h40);
    unlock(); wr(3'd1, 32'h41); wr(3'd1, 32'h50);
    rd(3'd1, d); check("R4 single use", d, 32'h41);
  endtask

  task automatic t_bad_keys();
    logic [31:0] d;
    wr(3'd4, 32'h0000_BABB); wr(3'd5, 32'h0000_EB10); wr(3'd1, 32'h60);
    rd(3'd1, d); check("R5 wrong first key", d, 32'h41);
    wr(3'd5, 32'h0000_EB10); wr(3'd4, 32'h0000_BABA); wr(3'd1, 32'h61);
    rd(3'd1, d); check("R5 reversed keys", d, 32'h41);
    wr(3'd4, 32'h0000_BABA); wr(3'd5, 32'h0000_EB11); wr(3'd1, 32'h62);
    rd(3'd1, d); check("R5 wrong second key", d, 32'h41);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    unlock(); rd(3'd2, d); wr(3'd1, 32'h70);
    rd(3'd1, d); check("R6 read cancels", d, 32'h41);
    unlock(); wr(3'd4, 32'h1); wr(3'd1, 32'h71);
    rd(3'd1, d); check("R6 key write cancels", d, 32'h41);
    unlock(); wr(3'd1, 32'hF);
    rd(3'd1, d); check("R2 limit 0xF", d, 32'hF);
  endtask

  task automatic t_count();
    logic [31:0] d;
    unlock(); wr(3'd0, 32'h1);
    idle(5);
    rd(3'd2, d); check("R7 count after 5 ticks", d, 32'd5);
    tick = 1'b0;
    idle(4);
    rd(3'd2, d); check("R7 hold without tick", d, 32'd6);
    tick = 1'b1;
    unlock(); wr(3'd0, 32'h0);
    rd(3'd2, d); check("R7 ctrl write restarts", d, 32'd0);
  endtask

  task automatic t_fire_reset();
    logic [31:0] d;
    unlock(); wr(3'd0, 32'h3);
    idle(15);
    check("R8 no request at count 15", {31'b0, wdt_rst_req}, 32'h0);
    idle(1);
    check("R8 request after 16 ticks", {31'b0, wdt_rst_req}, 32'h1);
    check("R8 no irq in reset mode", {31'b0, wdt_irq}, 32'h0);
    rd(3'd3, d); check("R8 flag set", d, 32'h1);
    rd(3'd2, d); check("R8 count stopped at 0", d, 32'h0);
    idle(10);
    check("R10 request held", {31'b0, wdt_rst_req}, 32'h1);
    wr(3'd3, 32'h0);
    check("R10 unprotected clear ignored", {31'b0, wdt_rst_req}, 32'h1);
    unlock(); wr(3'd3, 32'h1);
    check("R11 write of 1 ignored", {31'b0, wdt_rst_req}, 32'h1);
    unlock(); wr(3'd3, 32'h0);
    check("R10 protected clear", {31'b0, wdt_rst_req}, 32'h0);
    unlock(); wr(3'd0, 32'h0);
  endtask

  task automatic t_irq_mode();
    logic [31:0] d;
    unlock(); wr(3'd1, 32'h3);
    unlock(); wr(3'd0, 32'h1);
    idle(3);
    check("R9 no irq before limit", {31'b0, wdt_irq}, 32'h0);
    idle(1);
    check("R9 irq raised", {31'b0, wdt_irq}, 32'h1);
    check("R9 no reset request", {31'b0, wdt_rst_req}, 32'h0);
    unlock(); wr(3'd3, 32'h0);
    check("R9 irq cleared", {31'b0, wdt_irq}, 32'h0);
    unlock(); wr(3'd0, 32'h0);
    rd(3'd3, d); check("R9 flag clear", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    t_reset();
    t_locked();
    t_unlock_and_single();
    t_bad_keys();
    t_cancel();
    t_count();
    t_fire_reset();
    t_irq_mode();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule